// File: doc/BRIEF.md
# Multi-Task Activity Guard-Band Monitor

This block watches a set of software tasks and decides, once per check interval, whether all of them are alive and running at a sane rate. Every task pulses its own check-in line once per pass through its main loop. Each pulse advances a per-task saturating counter. A periodic evaluation tick closes the interval. At that moment every counter is compared against its own programmable lower and upper bound, and then all counters restart from zero.

If every task landed inside its band, the block sends a one-cycle kick to a downstream watchdog. If any task ran too slowly or too fast, there is no kick for that interval. Instead a sticky fault flag rises and the number of the lowest failing task is recorded. A runaway program that only toggles one line cannot keep the watchdog fed, because every task has to show the expected amount of activity.

The band limits are plain input ports. The reset is asynchronous and active low, and it is released through a two-stage synchronizer, so the block resumes operation on the second rising clock edge after the reset input goes high.

Top module: `task_band_monitor`

## Requirements
- R1: While reset is asserted, and after it is released, kick_o, bite_o and fault_idx_o are all 0.
- R2: Each check-in pulse on checkin_i[i] adds one to the activity count of task i only. The other tasks' counts are unchanged.
- R3: A task's count saturates at 2^CNT_W-1 (255 by default) and does not wrap. With a band of [255,255], 300 check-ins in one interval pass.
- R4: An evaluation uses the check-ins from the cycles after the previous tick, up to but not including the tick cycle. A check-in in the same cycle as eval_tick_i counts toward the next interval.
- R5: When every task's count c satisfies lo <= c <= hi, kick_o is high for exactly the one cycle after the tick.
- R6: When any task is outside its band at a tick, kick_o stays low and bite_o is high from the cycle after the tick.
- R7: bite_o stays high until reset. Later passing intervals still produce kicks.
- R8: fault_idx_o is a binary task number. It records the lowest-numbered failing task of the first failing interval and then holds until reset.
- R9: Task i takes its limits from lo_lim_i[i*CNT_W +: CNT_W] and hi_lim_i[i*CNT_W +: CNT_W]. Both bounds are inclusive. When lo > hi the band is empty and the task always fails.
- R10: All counts clear at every tick, whether the evaluation passes or fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| checkin_i | input | N_TASKS | One check-in pulse per task per loop pass |
| eval_tick_i | input | 1 | Periodic evaluation strobe that closes an interval |
| lo_lim_i | input | N_TASKS*CNT_W | Packed lower bounds, task i in slice i |
| hi_lim_i | input | N_TASKS*CNT_W | Packed upper bounds, task i in slice i |
| kick_o | output | 1 | One-cycle kick to the downstream watchdog |
| bite_o | output | 1 | Sticky fault flag |
| fault_idx_o | output | IDX_W | Lowest failing task of the first failing interval |

## Verification
The hardest condition to reach from the ports is counter saturation. A task has to check in more than 255 times inside a single interval, and the result is only visible as a pass or fail verdict at the next tick. The bench drives 300 consecutive pulses to one task and sets that task's band to exactly [255,255], so any wrap or stall below the top value shows up as a missing kick. The other subtle case is a check-in that coincides with the tick. The bench places pulses on the tick cycle and follows with a single further pulse, so the next verdict passes only if the coincident pulse was carried into the new interval.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  localparam int unsigned TBM_DEF_TASKS = 4;
  localparam int unsigned TBM_DEF_CNT_W = 8;

  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_PASS = 2'd1,
    VERDICT_FAIL = 2'd2
  } verdict_e;
endpackage

// File: rtl/tbm_reset_sync.sv
module tbm_reset_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tbm_entry_counter.sv
module tbm_entry_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             checkin_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Tick restarts the interval; a coincident check-in seeds the new one.
  always_comb begin
    cnt_en = clear_i | (checkin_i & (cnt_q != CNT_MAX));
    if (clear_i) cnt_d = checkin_i ? CNT_ONE : '0;
    else         cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3: saturation holds at the top value
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clear_i) |=> (cnt_q == CNT_MAX));

  // R10: after a tick the count holds at most the coincident pulse
  a_r10_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q <= CNT_ONE));

  // R2: a count never moves without a check-in or a tick
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!checkin_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tbm_band_check.sv
module tbm_band_check #(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             ok_o
);
  logic above_lo;
  logic below_hi;

  always_comb begin
    above_lo = (cnt_i >= lo_i);
    below_hi = (cnt_i <= hi_i);
    ok_o     = above_lo & below_hi;
  end
endmodule

// File: rtl/tbm_lowest_fail.sv
module tbm_lowest_fail #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     fail_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |fail_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (fail_i[i]) idx_o = IDX_W'(i);
    end
  end

  // R8: the reported task is really failing
  always_comb begin
    if (any_o) a_r8_idx_points_at_fail: assert (fail_i[idx_o]);
  end
endmodule

// File: rtl/task_band_monitor.sv
module task_band_monitor
  import tbm_pkg::*;
#(
  parameter int unsigned N_TASKS = TBM_DEF_TASKS,
  parameter int unsigned CNT_W   = TBM_DEF_CNT_W,
  localparam int unsigned IDX_W  = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_TASKS-1:0]         checkin_i,
  input  logic                       eval_tick_i,
  input  logic [N_TASKS*CNT_W-1:0]   lo_lim_i,
  input  logic [N_TASKS*CNT_W-1:0]   hi_lim_i,
  output logic                       kick_o,
  output logic                       bite_o,
  output logic [IDX_W-1:0]           fault_idx_o
);
  logic               rst_sync_n;
  logic [N_TASKS-1:0] band_ok;
  logic [N_TASKS-1:0] band_fail;
  logic               any_fail;
  logic [IDX_W-1:0]   low_idx;

  verdict_e         verdict_q, verdict_d;
  logic             bite_q, bite_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  tbm_reset_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  for (genvar g = 0; g < N_TASKS; g++) begin : g_task
    logic [CNT_W-1:0] cnt;

    tbm_entry_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .checkin_i (checkin_i[g]),
      .clear_i   (eval_tick_i),
      .cnt_o     (cnt)
    );

    tbm_band_check #(.CNT_W(CNT_W)) u_band (
      .cnt_i (cnt),
      .lo_i  (lo_lim_i[g*CNT_W +: CNT_W]),
      .hi_i  (hi_lim_i[g*CNT_W +: CNT_W]),
      .ok_o  (band_ok[g])
    );
  end

  assign band_fail = ~band_ok;

  tbm_lowest_fail #(.N(N_TASKS), .IDX_W(IDX_W)) u_enc (
    .fail_i (band_fail),
    .any_o  (any_fail),
    .idx_o  (low_idx)
  );

  always_comb begin
    if (!eval_tick_i)  verdict_d = VERDICT_NONE;
    else if (any_fail) verdict_d = VERDICT_FAIL;
    else               verdict_d = VERDICT_PASS;
    bite_d = bite_q | (eval_tick_i & any_fail);
    idx_en = eval_tick_i & any_fail & ~bite_q;
    idx_d  = low_idx;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      verdict_q <= VERDICT_NONE;
      bite_q    <= 1'b0;
    end else begin
      verdict_q <= verdict_d;
      bite_q    <= bite_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  idx_q <= '0;
    else if (idx_en)  idx_q <= idx_d;
  end

  assign kick_o      = (verdict_q == VERDICT_PASS);
  assign bite_o      = bite_q;
  assign fault_idx_o = idx_q;

  // R5: a kick only ever follows a tick
  a_r5_kick_after_tick: assert property (@(posedge clk) disable iff (!rst_sync_n)
    kick_o |-> $past(eval_tick_i));

  // R6: a failing evaluation suppresses the kick and raises the flag
  a_r6_fail_bites: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eval_tick_i && any_fail) |=> (bite_o && !kick_o));

  // R7: the fault flag is sticky
  a_r7_bite_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bite_o |=> bite_o);

  // R8: the recorded index is frozen once the flag is up
  a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bite_o |=> $stable(fault_idx_o));
endmodule

// File: tb/tb_task_band_monitor.sv
module tb_task_band_monitor;
  localparam int  CLK_P = 10;
  localparam int  NT    = 4;
  localparam int  CW    = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NT-1:0]  chk_r = '0;
  logic           tick_r = 1'b0;
  logic [NT*CW-1:0] lo_r = '0;
  logic [NT*CW-1:0] hi_r = '0;
  logic           kick;
  logic           bite;
  logic [1:0]     fidx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // behavioural reference state
  int m_cnt[NT];
  bit m_kick = 0;
  bit m_bite = 0;
  int m_idx  = 0;

  always #(CLK_P/2) clk = ~clk;

  task_band_monitor dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .checkin_i   (chk_r),
    .eval_tick_i (tick_r),
    .lo_lim_i    (lo_r),
    .hi_lim_i    (hi_r),
    .kick_o      (kick),
    .bite_o      (bite),
    .fault_idx_o (fidx)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_kick = 0; m_bite = 0; m_idx = 0;
    end else if (tick_r) begin
      int first;
      first = -1;
      for (int i = NT - 1; i >= 0; i--) begin
        if (m_cnt[i] < int'(lo_r[i*CW +: CW]) || m_cnt[i] > int'(hi_r[i*CW +: CW]))
          first = i;
      end
      m_kick = (first < 0);
      if (first >= 0 && !m_bite) begin
        m_bite = 1; m_idx = first;
      end
      for (int i = 0; i < NT; i++) m_cnt[i] = chk_r[i] ? 1 : 0;
    end else begin
      m_kick = 0;
      for (int i = 0; i < NT; i++)
        if (chk_r[i] && m_cnt[i] < 255) m_cnt[i]++;
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    if (!done) begin
      n_checks++;
      if (kick !== m_kick || bite !== m_bite || int'(fidx) !== m_idx) begin
        n_fail++;
        $display("FAIL R5/R7/R8 cycle compare: kick=%0b bite=%0b idx=%0d expected kick=%0b bite=%0b idx=%0d",
                 kick, bite, fidx, m_kick, m_bite, m_idx);
      end
    end
  end

  task automatic step(input logic [NT-1:0] m, input logic t);
    @(negedge clk);
    chk_r  = m;
    tick_r = t;
  endtask

  task automatic settle();
    @(posedge clk);
    #(CLK_P/4 + 1);
  endtask

  task automatic expect_out(input bit k, input bit b, input int ix, input string req);
    n_checks++;
    if (kick !== k || bite !== b || int'(fidx) !== ix) begin
      n_fail++;
      $display("FAIL %s: kick=%0b bite=%0b idx=%0d expected kick=%0b bite=%0b idx=%0d",
               req, kick, bite, fidx, k, b, ix);
    end
  endtask

  task automatic set_band(input int i, input int lo, input int hi);
    lo_r[i*CW +: CW] = CW'(lo);
    hi_r[i*CW +: CW] = CW'(hi);
  endtask

  task automatic all_bands(input int lo, input int hi);
    for (int i = 0; i < NT; i++) set_band(i, lo, hi);
  endtask

  task automatic do_reset();
    @(negedge clk);
    chk_r = '0; tick_r = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step('0, 1'b0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    all_bands(2, 5);
    repeat (2) @(negedge clk);
    expect_out(0, 0, 0, "R1 during reset");
    rst_n = 1'b1;
    repeat (4) step('0, 1'b0);
    settle();
    expect_out(0, 0, 0, "R1 after release");

    // R2/R5: three pulses each, coincident pulses on the tick (R4)
    repeat (3) step(4'hF, 1'b0);
    step(4'hF, 1'b1);
    settle();
    expect_out(1, 0, 0, "R5 kick after passing tick");
    step('0, 1'b0);
    settle();
    expect_out(0, 0, 0, "R5 kick lasts one cycle");

    // R4/R10/R9: one more pulse plus the carried one -> 2, at the lower bound
    step(4'hF, 1'b0);
    step('0, 1'b1);
    settle();
    expect_out(1, 0, 0, "R4 coincident check-in carried over");

    // R9: exactly at the upper bound
    repeat (5) step(4'hF, 1'b0);
    step('0, 1'b1);
    settle();
    expect_out(1, 0, 0, "R9 upper bound inclusive");

    // R3: saturation
    all_bands(0, 255);
    set_band(2, 255, 255);
    repeat (300) step(4'b0100, 1'b0);
    step('0, 1'b1);
    settle();
    expect_out(1, 0, 0, "R3 saturate at 255");

    // R6/R8: tasks 1 and 3 idle
    all_bands(2, 5);
    repeat (3) step(4'b0101, 1'b0);
    step('0, 1'b1);
    settle();
    expect_out(0, 1, 1, "R6 fail no kick, R8 lowest index");

    // R7: passing interval still kicks, flag sticky
    repeat (3) step(4'hF, 1'b0);
    step('0, 1'b1);
    settle();
    expect_out(1, 1, 1, "R7 sticky bite with kick");

    // R8: new failure on task 0 does not replace index; R10 counts cleared
    repeat (3) step(4'b1110, 1'b0);
    step('0, 1'b1);
    settle();
    expect_out(0, 1, 1, "R8 index held");

    // R9: empty band on task 0
    do_reset();
    settle();
    expect_out(0, 0, 0, "R1 reset clears bite");
    all_bands(0, 255);
    set_band(0, 6, 3);
    repeat (4) step(4'b0001, 1'b0);
    step('0, 1'b1);
    settle();
    expect_out(0, 1, 0, "R9 lo above hi fails");

    // R2: task 3 too fast alone, others untouched
    do_reset();
    all_bands(0, 2);
    repeat (3) step(4'b1000, 1'b0);
    step('0, 1'b1);
    settle();
    expect_out(0, 1, 3, "R2 per-task counting");

    step('0, 1'b0);
    settle();
    finish_run();
  end
endmodule